// File: doc/BRIEF.md
# Synchronizing Bit Error Counter

This block sits on the receive side of a serial link test setup. Each cycle with the bit enable high, it samples one received bit. It holds a local reference generator that predicts the next bit, and it compares every sampled bit against that prediction. The reference can be a 15-stage maximal-length pseudo-random sequence or a repeating 16-bit word. The block finds its own alignment to the incoming stream and only then starts measuring. It does not need to know the transmitter's starting phase.

Measurement runs in blocks of a selectable number of bits: one million, one hundred million or ten billion by default. While a block runs, a gating flag is high. At the end of each block, the mismatch count is latched onto the output and a one-cycle strobe marks it. A separate flag reports when the block is not aligned to the stream. Alignment is dropped when errors come too densely, and it is then re-acquired without outside help. A block that saw alignment dropped is marked as unreliable.

Top module: `bit_err_counter`

## Requirements
- R1: After reset, sync_lost is 1, and gating, result_valid, result_bad and err_count are all 0.
- R2: A bit is taken only on a rising clock edge with bit_en high. bit_in has no effect in any other cycle.
- R3: When pat_mode is 0, the expected stream obeys b[n] = b[n-15] XOR b[n-14]. Acquisition loads the last 15 received bits as the generator state on the 15th bit after acquisition starts. A load of all zeros is refused and acquisition goes on, so a line stuck at 0 or stuck at 1 never aligns.
- R4: When pat_mode is 1, pat_word is expected most significant bit first, repeated without gaps, at any phase. Once 16 bits are held, the last 16 received bits are compared against all 16 rotations of the word on every bit, and a hit aligns the reference.
- R5: After the reference is loaded, 32 further consecutive matching bits make the block synchronized. sync_lost falls on the edge that samples the 32nd match. A mismatch during these 32 bits restarts acquisition.
- R6: While synchronized, if more than 8 of the last 64 sampled bits are mismatches, synchronization is dropped on that bit (sync_lost rises) and acquisition restarts from empty.
- R7: A block starts on the first bit sampled while synchronized with no block running. gating rises with that bit and falls on the edge that samples the block's last bit.
- R8: len_sel 0 selects LEN_SHORT bits, 1 selects LEN_MID and 2 or 3 select LEN_LONG. The value is taken at block start, and a change during a block has no effect on that block.
- R9: Mismatches count only for bits sampled while synchronized. Bits taken during acquisition or verification still count towards block length.
- R10: On the edge that samples a block's last bit, err_count takes that block's mismatch total and result_valid is high for exactly one cycle. At all other times err_count holds its value.
- R11: result_bad is latched with err_count. It is 1 when synchronization was dropped at any bit of that block.
- R12: The block's mismatch total saturates at 2^ERR_W-1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock domain |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Marks a cycle that carries a received bit |
| bit_in | input | 1 | Received data bit |
| pat_mode | input | 1 | 0: pseudo-random reference, 1: repeating word |
| pat_word | input | 16 | Expected repeating word |
| len_sel | input | 2 | Block length select |
| err_count | output | ERR_W | Mismatch total of the last finished block |
| gating | output | 1 | A measurement block is running |
| sync_lost | output | 1 | Reference not aligned to the received stream |
| result_valid | output | 1 | One-cycle strobe: new err_count and result_bad |
| result_bad | output | 1 | Last finished block saw synchronization dropped |

## Verification
Two events can fall on one sampled bit: counting a mismatch into the running block, and dropping synchronization because of that same mismatch. The bench provokes this with nine consecutive corrupted bits inside a block. It checks that the ninth is still counted, that sync_lost rises on that bit and that the block later reports result_bad. A second case fills the rest of the block with a stuck line, so the block ends while the unit is still hunting. The expected total must then hold only the errors counted while aligned. A third case re-locks inside the block, and the bench checks that a later error is counted again.

// File: rtl/bec_pkg.sv
`timescale 1ns/1ps
package bec_pkg;
  localparam int PRBS_W = 15;
  localparam int PAT_W  = 16;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCK   = 2'd2
  } sync_st_e;

  // Next bit of x^15 + x^14 + 1, state newest bit at index 0.
  function automatic logic prbs_next_bit(input logic [PRBS_W-1:0] s);
    return s[PRBS_W-1] ^ s[PRBS_W-2];
  endfunction

  // Word as seen in a newest-at-0 history when the last bit sent was w[k].
  function automatic logic [PAT_W-1:0] rot_right(input logic [PAT_W-1:0] w, input int k);
    logic [PAT_W-1:0] r;
    for (int j = 0; j < PAT_W; j++) r[j] = w[(j + k) % PAT_W];
    return r;
  endfunction
endpackage

// File: rtl/bec_refgen.sv
`timescale 1ns/1ps
module bec_refgen import bec_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pat_mode,
  input  logic [PAT_W-1:0] pat_word,
  input  logic [PAT_W-1:0] recent,
  input  logic             load,
  input  logic             advance,
  output logic             seed_ok,
  output logic             exp_bit
);
  localparam int PTR_W = $clog2(PAT_W);

  logic [PRBS_W-1:0] lfsr;
  logic [PTR_W-1:0]  ptr;
  logic [PAT_W-1:0]  hit;
  logic [PTR_W-1:0]  hit_k;

  // one comparator per rotation of the word
  for (genvar k = 0; k < PAT_W; k++) begin : g_rot
    assign hit[k] = (rot_right(pat_word, k) == recent);
  end

  always_comb begin
    hit_k = '0;
    for (int k = PAT_W - 1; k >= 0; k--)
      if (hit[k]) hit_k = PTR_W'(k);
  end

  assign seed_ok = pat_mode ? (|hit) : (|recent[PRBS_W-1:0]);
  assign exp_bit = pat_mode ? pat_word[ptr] : prbs_next_bit(lfsr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= '0;
      ptr  <= '0;
    end else if (load) begin
      lfsr <= recent[PRBS_W-1:0];
      ptr  <= hit_k - PTR_W'(1);
    end else if (advance) begin
      lfsr <= {lfsr[PRBS_W-2:0], prbs_next_bit(lfsr)};
      ptr  <= ptr - PTR_W'(1);
    end
  end

  // R3: once loaded or stepping, the sequence state never collapses to zero
  p_ref_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pat_mode && $past(load || advance)) |-> (|lfsr));
endmodule

// File: rtl/bec_sync.sv
`timescale 1ns/1ps
module bec_sync import bec_pkg::*; #(
  parameter int VERIFY_RUN = 32,
  parameter int WIN_LEN    = 64,
  parameter int WIN_MAX    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             pat_mode,
  input  logic             exp_bit,
  input  logic             seed_ok,
  output logic [PAT_W-1:0] recent,
  output logic             load,
  output logic             advance,
  output logic             locked,
  output logic             err_bit,
  output logic             lose_evt
);
  localparam int FILL_W = $clog2(PAT_W + 1);
  localparam int RUN_W  = $clog2(VERIFY_RUN);
  localparam int WC_W   = $clog2(WIN_LEN + 1);

  sync_st_e           st;
  logic [PAT_W-1:0]   hist;
  logic [FILL_W-1:0]  fill, need_m1;
  logic [RUN_W-1:0]   run;
  logic [WIN_LEN-1:0] win;
  logic [WC_W-1:0]    wcnt, wcnt_nxt;
  logic               full, mism;

  assign recent   = {hist[PAT_W-2:0], bit_in};
  assign need_m1  = pat_mode ? FILL_W'(PAT_W - 1) : FILL_W'(PRBS_W - 1);
  assign full     = (fill >= need_m1);
  assign mism     = bit_in ^ exp_bit;
  assign load     = bit_en && (st == ST_HUNT) && full && seed_ok;
  assign advance  = bit_en && (st != ST_HUNT);
  assign locked   = (st == ST_LOCK);
  assign err_bit  = bit_en && locked && mism;
  assign wcnt_nxt = wcnt + WC_W'(err_bit) - WC_W'(win[WIN_LEN-1]);
  assign lose_evt = err_bit && (wcnt_nxt > WC_W'(WIN_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_HUNT;
      hist <= '0;
      fill <= '0;
      run  <= '0;
      win  <= '0;
      wcnt <= '0;
    end else if (bit_en) begin
      hist <= recent;
      unique case (st)
        ST_HUNT: begin
          if (load) begin
            st  <= ST_VERIFY;
            run <= '0;
          end else if (!full) begin
            fill <= fill + FILL_W'(1);
          end
        end
        ST_VERIFY: begin
          if (mism) begin
            st   <= ST_HUNT;
            fill <= '0;
          end else if (run == RUN_W'(VERIFY_RUN - 1)) begin
            st <= ST_LOCK;
          end else begin
            run <= run + RUN_W'(1);
          end
        end
        default: begin
          if (lose_evt) begin
            st   <= ST_HUNT;
            fill <= '0;
            win  <= '0;
            wcnt <= '0;
          end else begin
            win  <= {win[WIN_LEN-2:0], err_bit};
            wcnt <= wcnt_nxt;
          end
        end
      endcase
    end
  end

  // R5: lock is only ever entered at the end of a full matching run
  p_lock_after_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(st) == ST_VERIFY) && $past(bit_en) && !$past(mism)
                      && ($past(run) == RUN_W'(VERIFY_RUN - 1)));
  // R6: while aligned the window tally never passes the limit
  p_win_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (wcnt <= WC_W'(WIN_MAX)));
  // R6: a drop always leaves the unit hunting from empty
  p_hunt_after_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lose_evt |=> (st == ST_HUNT) && (fill == '0));
endmodule

// File: rtl/bec_gate.sv
`timescale 1ns/1ps
module bec_gate #(
  parameter int              CNT_W     = 34,
  parameter int              ERR_W     = 34,
  parameter longint unsigned LEN_SHORT = 64'd1_000_000,
  parameter longint unsigned LEN_MID   = 64'd100_000_000,
  parameter longint unsigned LEN_LONG  = 64'd10_000_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             locked,
  input  logic             err_bit,
  input  logic             lose_evt,
  input  logic [1:0]       len_sel,
  output logic             gating,
  output logic [ERR_W-1:0] err_count,
  output logic             result_valid,
  output logic             result_bad
);
  localparam logic [CNT_W-1:0] LEN_A = CNT_W'(LEN_SHORT);
  localparam logic [CNT_W-1:0] LEN_B = CNT_W'(LEN_MID);
  localparam logic [CNT_W-1:0] LEN_C = CNT_W'(LEN_LONG);

  function automatic logic [CNT_W-1:0] pick_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return LEN_A;
      2'd1:    return LEN_B;
      default: return LEN_C;
    endcase
  endfunction

  function automatic logic [ERR_W-1:0] sat_inc(input logic [ERR_W-1:0] v, input logic inc);
    if (inc && (v != '1)) return v + ERR_W'(1);
    return v;
  endfunction

  logic [CNT_W-1:0] bcnt, blen_q;
  logic [ERR_W-1:0] errs, errs_nxt;
  logic             bad, last_bit;

  assign errs_nxt = sat_inc(errs, err_bit);
  assign last_bit = gating && (bcnt == blen_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gating       <= 1'b0;
      bcnt         <= '0;
      blen_q       <= LEN_A;
      errs         <= '0;
      bad          <= 1'b0;
      err_count    <= '0;
      result_valid <= 1'b0;
      result_bad   <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (bit_en) begin
        if (!gating) begin
          if (locked) begin
            gating <= 1'b1;
            bcnt   <= CNT_W'(1);
            blen_q <= pick_len(len_sel);
            errs   <= ERR_W'(err_bit);
            bad    <= lose_evt;
          end
        end else if (last_bit) begin
          gating       <= 1'b0;
          bcnt         <= '0;
          err_count    <= errs_nxt;
          result_bad   <= bad | lose_evt;
          result_valid <= 1'b1;
        end else begin
          bcnt <= bcnt + CNT_W'(1);
          errs <= errs_nxt;
          bad  <= bad | lose_evt;
        end
      end
    end
  end

  // R10: the strobe is a single cycle
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  // R10: the latched result only moves together with the strobe
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_count) |-> result_valid);
  // R7: a block only opens while aligned
  p_gate_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gating) |-> $past(locked) && $past(bit_en));
  // R8: position stays inside the length chosen at block start
  p_len_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gating |-> (bcnt != '0) && (bcnt < blen_q));
  // R12: within one block the tally never decreases (no wrap)
  p_no_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (gating && $past(gating)) |-> (errs >= $past(errs)));
endmodule

// File: rtl/bit_err_counter.sv
`timescale 1ns/1ps
module bit_err_counter import bec_pkg::*; #(
  parameter int              CNT_W      = 34,
  parameter int              ERR_W      = 34,
  parameter longint unsigned LEN_SHORT  = 64'd1_000_000,
  parameter longint unsigned LEN_MID    = 64'd100_000_000,
  parameter longint unsigned LEN_LONG   = 64'd10_000_000_000,
  parameter int              VERIFY_RUN = 32,
  parameter int              WIN_LEN    = 64,
  parameter int              WIN_MAX    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             pat_mode,
  input  logic [PAT_W-1:0] pat_word,
  input  logic [1:0]       len_sel,
  output logic [ERR_W-1:0] err_count,
  output logic             gating,
  output logic             sync_lost,
  output logic             result_valid,
  output logic             result_bad
);
  logic [PAT_W-1:0] recent;
  logic load, advance, seed_ok, exp_bit;
  logic locked, err_bit, lose_evt;

  bec_refgen u_ref (
    .clk(clk), .rst_n(rst_n), .pat_mode(pat_mode), .pat_word(pat_word),
    .recent(recent), .load(load), .advance(advance),
    .seed_ok(seed_ok), .exp_bit(exp_bit)
  );

  bec_sync #(.VERIFY_RUN(VERIFY_RUN), .WIN_LEN(WIN_LEN), .WIN_MAX(WIN_MAX)) u_sync (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .pat_mode(pat_mode),
    .exp_bit(exp_bit), .seed_ok(seed_ok), .recent(recent), .load(load),
    .advance(advance), .locked(locked), .err_bit(err_bit), .lose_evt(lose_evt)
  );

  bec_gate #(.CNT_W(CNT_W), .ERR_W(ERR_W), .LEN_SHORT(LEN_SHORT),
             .LEN_MID(LEN_MID), .LEN_LONG(LEN_LONG)) u_gate (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .locked(locked), .err_bit(err_bit),
    .lose_evt(lose_evt), .len_sel(len_sel), .gating(gating), .err_count(err_count),
    .result_valid(result_valid), .result_bad(result_bad)
  );

  assign sync_lost = ~locked;

  // R9: no mismatch reaches the tally unless aligned before this bit
  p_count_when_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_bit |-> !sync_lost);
endmodule

// File: tb/tb_bit_err_counter.sv
`timescale 1ns/1ps
module tb_bit_err_counter;
  localparam int EW = 5;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0, pat_mode = 1'b0;
  logic [15:0] pat_word = 16'hC3A5;
  logic [1:0]  len_sel = 2'd0;
  logic [EW-1:0] err_count;
  logic gating, sync_lost, result_valid, result_bad;

  bit_err_counter #(.ERR_W(EW), .LEN_SHORT(64'd100), .LEN_MID(64'd200), .LEN_LONG(64'd400)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .pat_mode(pat_mode),
    .pat_word(pat_word), .len_sel(len_sel), .err_count(err_count), .gating(gating),
    .sync_lost(sync_lost), .result_valid(result_valid), .result_bad(result_bad)
  );

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int gidx = 0;
  logic [14:0] gs;
  int pidx;
  int flips[$];
  int stuck_from = 0;
  logic stuck_val = 1'b0;

  typedef struct { int err; bit bad; int endb; string req; } exp_t;
  exp_t exp_q[$];

  task automatic check(input string tag, input longint act, input longint expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (bit %0d)", tag, act, expv, gidx);
    end
  endtask

  task automatic expect_blk(input int e, input bit b, input int endb, input string req);
    exp_t x;
    x.err = e; x.bad = b; x.endb = endb; x.req = req;
    exp_q.push_back(x);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && result_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10 unexpected result: actual err %0d expected none (bit %0d)", err_count, gidx);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.req, " err_count"}, longint'(err_count), longint'(e.err));
        check({e.req, " result_bad"}, longint'(result_bad), longint'(e.bad));
        check({e.req, " R10 end bit"}, longint'(gidx), longint'(e.endb));
      end
    end
  end

  task automatic send_next(input int gap);
    logic b;
    if (pat_mode) begin
      b = pat_word[pidx];
      pidx = (pidx + 15) % 16;
    end else begin
      b = gs[14] ^ gs[13];
      gs = {gs[13:0], b};
    end
    if (flips.size() > 0 && flips[0] == gidx + 1) begin
      b = ~b;
      void'(flips.pop_front());
    end
    if (stuck_from > 0 && gidx + 1 >= stuck_from) b = stuck_val;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      bit_in = ~bit_in;   // R2: junk on idle cycles
    end
    @(negedge clk);
    bit_in = b;
    bit_en = 1'b1;
    @(posedge clk);
    #1;
    bit_en = 1'b0;
    gidx++;
  endtask

  task automatic run_to(input int upto, input bit gaps);
    while (gidx < upto) send_next((gaps && (gidx % 7 == 3)) ? 2 : 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bit_en = 1'b0;
    gidx = 0;
    flips.delete();
    stuck_from = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic end_test(input string tag);
    check({tag, " R10 results pending"}, longint'(exp_q.size()), 0);
    exp_q.delete();
  endtask

  initial begin
    // reset state
    do_reset();
    check("R1 sync_lost", sync_lost, 1);
    check("R1 gating", gating, 0);
    check("R1 result_valid", result_valid, 0);
    check("R1 err_count", err_count, 0);
    check("R1 result_bad", result_bad, 0);

    // A: pseudo-random, short blocks, gapped enables
    pat_mode = 1'b0; gs = 15'h1ACE; len_sel = 2'd0;
    flips = '{60, 100, 150, 151, 152};
    expect_blk(2, 0, 147, "R2 R9");
    expect_blk(3, 0, 247, "R2 R10");
    expect_blk(0, 0, 347, "R10");
    run_to(46, 1);  check("R5 before run end", sync_lost, 1);
    run_to(47, 1);  check("R3 R5 lock", sync_lost, 0);
    check("R7 no gate on lock bit", gating, 0);
    run_to(48, 1);  check("R7 gate opens", gating, 1);
    run_to(147, 1); check("R7 gate closes", gating, 0);
    run_to(350, 1);
    end_test("A");

    // B: repeating word at arbitrary phase, length change mid-block
    do_reset();
    pat_mode = 1'b1; pidx = 9; len_sel = 2'd1;
    flips = '{70, 200, 300};
    expect_blk(2, 0, 248, "R4 R8");
    expect_blk(1, 0, 348, "R8");
    run_to(47, 0);  check("R4 R5 before run end", sync_lost, 1);
    run_to(48, 0);  check("R4 R5 lock", sync_lost, 0);
    run_to(100, 0); len_sel = 2'd0;
    run_to(350, 0);
    end_test("B");

    // C1: drop inside a block, then a stuck line until block end
    do_reset();
    pat_mode = 1'b0; gs = 15'h7001; len_sel = 2'd0;
    for (int i = 70; i <= 78; i++) flips.push_back(i);
    stuck_from = 79; stuck_val = 1'b0;
    expect_blk(9, 1, 147, "R9 R11");
    run_to(77, 0);  check("R6 still aligned at 8 errors", sync_lost, 0);
    run_to(78, 0);  check("R6 drop at 9 errors", sync_lost, 1);
    run_to(150, 0);
    check("R7 no new block while hunting", gating, 0);
    check("R3 zero line never aligns", sync_lost, 1);
    end_test("C1");

    // C2: drop and re-acquire inside a block
    do_reset();
    pat_mode = 1'b0; gs = 15'h2B3C; len_sel = 2'd0;
    for (int i = 70; i <= 78; i++) flips.push_back(i);
    flips.push_back(140);
    expect_blk(10, 1, 147, "R6 R11");
    expect_blk(0, 0, 247, "R11");
    run_to(124, 0); check("R6 R5 relock pending", sync_lost, 1);
    run_to(125, 0); check("R6 R5 relock", sync_lost, 0);
    run_to(250, 0);
    end_test("C2");

    // D: saturation, len_sel 3 maps to the long length
    do_reset();
    pat_mode = 1'b0; gs = 15'h0F0F; len_sel = 2'd3;
    for (int i = 50; i <= 447; i += 9) flips.push_back(i);
    expect_blk(31, 0, 447, "R8 R12");
    run_to(450, 1);
    check("R7 next block running", gating, 1);
    end_test("D");

    // E: lines that must never align
    do_reset();
    pat_mode = 1'b0; gs = 15'h1234; stuck_from = 1; stuck_val = 1'b0;
    run_to(150, 0);
    check("R3 stuck 0 sync_lost", sync_lost, 1);
    check("R3 stuck 0 gating", gating, 0);
    do_reset();
    stuck_from = 1; stuck_val = 1'b1;
    run_to(150, 0);
    check("R3 stuck 1 sync_lost", sync_lost, 1);
    do_reset();
    pat_mode = 1'b1; pidx = 3; stuck_from = 1; stuck_val = 1'b0;
    run_to(150, 0);
    check("R4 no rotation match", sync_lost, 1);
    end_test("E");

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule